// File: doc/BRIEF.md
# Instruction Privilege Check Unit

This block decides whether a fetched instruction may execute at the ring the core currently runs in. Three rings exist: ring 0 is the most trusted level and sits beneath the operating system, ring 1 hosts the kernel, and ring 2 runs user applications. Each opcode carries its own lowest-trust ring, the "required level", taken from an internal table. An instruction is allowed when the current ring number is no greater than that level. For example, a level-2 opcode runs in rings 0, 1 and 2, while a level-0 opcode runs only in ring 0.

The fetch stage presents a 32-bit instruction word, the current ring and a valid strobe. One clock later the block returns a registered verdict: a permit or a fault, and the required level it looked up, so that trap logic can see which ring the opcode needed. The table is computed in logic, so it needs no external file. Decoding beyond the opcode field, trap vectors and ring changes are handled elsewhere.

Top module: `priv_check_top`

## Requirements
- R1: The opcode is bits [31:24] of the instruction. Its required level is 2 when the opcode's top two bits are 00 or 01, and 1 when they are 10. When they are 11, the level is 0 for opcodes 0xC0 through 0xFB and 3 for opcodes 0xFC through 0xFF. The level appears on `reqLevel` with the verdict.
- R2: For a legal ring (0, 1 or 2) and a non-reserved opcode, `permit` is 1 exactly when the ring number is less than or equal to the required level. Otherwise `fault` is 1.
- R3: An opcode whose required level is 3 is reserved. It produces `fault` at every ring.
- R4: A current-ring value of 3 is illegal. It produces `fault` for every opcode.
- R5: `resValid` is `instValid` delayed by exactly one clock. The verdict reflects the inputs sampled on that edge, and back-to-back instructions are accepted every cycle.
- R6: While `resValid` is 1, exactly one of `permit` and `fault` is 1. While `resValid` is 0, `permit`, `fault` and `reqLevel` are all 0.
- R7: While `rstN` is low, `resValid`, `permit`, `fault` and `reqLevel` are 0. This holds even if `instValid` is high.
- R8: Instruction bits [23:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word and ring are valid this cycle |
| instWord | input | 32 | Fetched instruction; opcode in [31:24] |
| curRing | input | 2 | Current privilege ring (3 is illegal) |
| resValid | output | 1 | Verdict valid, one clock after instValid |
| permit | output | 1 | Instruction may execute |
| fault | output | 1 | Instruction must trap |
| reqLevel | output | 2 | Required level looked up for the opcode |

## Verification
The hardest cases to reach are the corners where two fault causes meet: the reserved opcodes 0xFC to 0xFF, the illegal ring 3, and both together. A bench that picks samples at random would hit these rarely. The stimulus therefore sweeps all 256 opcodes against all four ring values in back-to-back cycles. It varies the low 24 bits with a pattern that changes from one instruction to the next, and it inserts idle cycles and a reset while an instruction is valid.

// File: rtl/priv_check_pkg.sv
package priv_check_pkg;

  parameter int INST_W  = 32;
  parameter int OPC_W   = 8;
  parameter int OPC_LSB = INST_W - OPC_W;
  parameter int RING_W  = 2;
  localparam int TABLE_DEPTH = 1 << OPC_W;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic load;   // capture a new verdict
    logic flush;  // drive the result registers to zero
  } ctrlStrobe_t;

  // Required level for each opcode. Level 3 marks a reserved opcode.
  function automatic logic [RING_W-1:0] levelOf(input logic [OPC_W-1:0] opc);
    logic [RING_W-1:0] lvl;
    unique case (opc[OPC_W-1 -: 2])
      2'b00, 2'b01: lvl = 2'd2;
      2'b10:        lvl = 2'd1;
      default:      lvl = (opc[OPC_W-3 -: 4] == 4'hF) ? 2'd3 : 2'd0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/priv_check_ctrl.sv
module priv_check_ctrl
  import priv_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  output ctrlStrobe_t strobe,
  output logic        resValid
);

  always_comb begin
    strobe.load  = instValid;
    strobe.flush = !instValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= instValid;
  end

endmodule

// File: rtl/priv_check_dp.sv
module priv_check_dp
  import priv_check_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [INST_W-1:0] instWord,
  input  logic [RING_W-1:0] curRing,
  output logic              permit,
  output logic              fault,
  output logic [RING_W-1:0] reqLevel
);

  localparam logic [RING_W-1:0] RESERVED = {RING_W{1'b1}};

  logic [RING_W-1:0] levelTable [TABLE_DEPTH];

  for (genvar gi = 0; gi < TABLE_DEPTH; gi++) begin : g_table
    assign levelTable[gi] = levelOf(gi[OPC_W-1:0]);
  end

  logic [OPC_W-1:0]  opcode;
  logic [RING_W-1:0] lookLevel;
  logic              ringBad;
  logic              opcBad;
  logic              allowNext;

  always_comb begin
    opcode    = instWord[OPC_LSB +: OPC_W];
    lookLevel = levelTable[opcode];
    ringBad   = (curRing == RESERVED);
    opcBad    = (lookLevel == RESERVED);
    allowNext = !ringBad && !opcBad && (curRing <= lookLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permit   <= 1'b0;
      fault    <= 1'b0;
      reqLevel <= '0;
    end else if (strobe.load) begin
      permit   <= allowNext;
      fault    <= !allowNext;
      reqLevel <= lookLevel;
    end else if (strobe.flush) begin
      permit   <= 1'b0;
      fault    <= 1'b0;
      reqLevel <= '0;
    end
  end

endmodule

// File: rtl/priv_check_top.sv
module priv_check_top
  import priv_check_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [RING_W-1:0] curRing,
  output logic              resValid,
  output logic              permit,
  output logic              fault,
  output logic [RING_W-1:0] reqLevel
);

  ctrlStrobe_t strobe;

  priv_check_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .strobe    (strobe),
    .resValid  (resValid)
  );

  priv_check_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .instWord (instWord),
    .curRing  (curRing),
    .permit   (permit),
    .fault    (fault),
    .reqLevel (reqLevel)
  );

endmodule

// File: rtl/priv_check_sva.sv
module priv_check_sva
  import priv_check_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [INST_W-1:0] instWord,
  input logic [RING_W-1:0] curRing,
  input logic              resValid,
  input logic              permit,
  input logic              fault,
  input logic [RING_W-1:0] reqLevel
);

  a_r6_onehot_when_valid: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones({permit, fault}) == 1));

  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!permit && !fault && reqLevel == '0));

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> resValid);

  a_r5_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !resValid);

  a_r4_bad_ring_faults: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && curRing == 2'd3) |=> fault);

  a_r3_reserved_faults: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && reqLevel == 2'd3) |-> fault);

  a_r2_permit_ring_ok: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && curRing == 2'd0 && instWord[INST_W-1 -: 2] != 2'b11) |=> permit);

  a_r7_reset_clear: assert property (@(posedge clk)
    !rstN |-> (!resValid && !permit && !fault));

endmodule

bind priv_check_top priv_check_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .instWord  (instWord),
  .curRing   (curRing),
  .resValid  (resValid),
  .permit    (permit),
  .fault     (fault),
  .reqLevel  (reqLevel)
);

// File: tb/test_priv_check_top.sv
`timescale 1ns/1ps
module test_priv_check_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [1:0]  curRing = '0;
  logic        resValid, permit, fault;
  logic [1:0]  reqLevel;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  priv_check_top i_priv_check_top (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .curRing(curRing), .resValid(resValid), .permit(permit),
    .fault(fault), .reqLevel(reqLevel)
  );

  function automatic logic [1:0] expLevel(input int op);
    if (op < 128)  return 2'd2;
    if (op < 192)  return 2'd1;
    if (op >= 252) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {v,p,f,lvl}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] verdict(input int op, input int ring);
    logic [1:0] l;
    logic ok;
    l  = expLevel(op);
    ok = (ring != 3) && (l != 2'd3) && (ring <= int'(l));
    return {1'b1, ok, !ok, l};
  endfunction

  initial begin : watchdog
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [4:0] pend;
    logic       havePend;
    string      tag;
    havePend = 1'b0;
    pend = '0;
    // R7: outputs held at zero during reset even with valid high
    instValid = 1'b1;
    instWord  = 32'h0000_0000;
    repeat (3) @(negedge clk);
    check("R7 reset", {resValid, permit, fault, reqLevel}, 5'b0);
    rstN = 1'b1;
    instValid = 1'b0;
    @(negedge clk);
    check("R6 idle after reset", {resValid, permit, fault, reqLevel}, 5'b0);

    // R1 R2 R3 R4 R5 R8: full sweep of opcode x ring, back to back
    for (int op = 0; op < 256; op++) begin
      for (int ring = 0; ring < 4; ring++) begin
        instValid = 1'b1;
        instWord  = {op[7:0], 24'(op * 40503 + ring * 7919) ^ 24'hA5C3_96};
        curRing   = ring[1:0];
        @(negedge clk);
        if (ring == 3)                          tag = "R4 illegal ring";
        else if (expLevel(op) == 2'd3)          tag = "R3 reserved";
        else                                    tag = "R1 R2 R5 R8 lookup";
        check(tag, {resValid, permit, fault, reqLevel}, verdict(op, ring));
      end
      if (op % 16 == 15) begin
        instValid = 1'b0;
        instWord  = 32'hFFFF_FFFF;
        curRing   = 2'd3;
        @(negedge clk);
        check("R5 R6 idle gap", {resValid, permit, fault, reqLevel}, 5'b0);
      end
    end

    // R8: same opcode, extreme low bits
    for (int k = 0; k < 4; k++) begin
      instValid = 1'b1;
      instWord  = {8'h85, (k[0] ? 24'hFFFFFF : 24'h000000)};
      curRing   = k[1] ? 2'd1 : 2'd2;
      @(negedge clk);
      check("R8 low bits ignored", {resValid, permit, fault, reqLevel},
            verdict(8'h85, k[1] ? 1 : 2));
    end

    // R7: reset asserted mid-stream
    instValid = 1'b1;
    instWord  = 32'h1200_0000;
    curRing   = 2'd0;
    @(negedge clk);
    check("R2 before reset", {resValid, permit, fault, reqLevel}, verdict(8'h12, 0));
    rstN = 1'b0;
    #1;
    check("R7 async clear", {resValid, permit, fault, reqLevel}, 5'b0);
    @(negedge clk);
    check("R7 held in reset", {resValid, permit, fault, reqLevel}, 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 resume", {resValid, permit, fault, reqLevel}, verdict(8'h12, 0));
    instValid = 1'b0;
    @(negedge clk);
    check("R6 final idle", {resValid, permit, fault, reqLevel}, 5'b0);

    if (havePend) check("unused", pend, pend);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule